// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Error Status

This block turns an asynchronous serial line into characters. An oversampling tick runs at sixteen times the bit rate and paces the block. When the receiver is enabled, it waits for a falling edge on the line. It confirms the start condition at the middle of the bit, then samples each later bit at its centre. The bits are the data bits (least significant first), an optional parity bit, an optional wake-up bit and one stop bit. A finished character goes into a single receive buffer.

A small status/control byte gives the processor four bits:
- A receive enable, which can be read and written.
- A character-available flag. A buffer read clears it; a write does not change it.
- A sticky parity error flag, cleared by writing 1.
- A sticky overrun error flag, cleared by writing 1.

The block also reports, for each character, whether the stop bit was missing and whether the wake-up bit matched a compare value that the host supplies. A one-cycle pulse marks the cycle in which a new character and its flags become visible. Baud generation, interrupts and the policy applied on a wake-up mismatch are left to the surrounding logic.

Top module: `uart_rx_status`

## Requirements
- R1: After synchronous reset, every bit of `status` is 0. `rx_done`, `frame_err`, `wake_match` and `rx_data` are also 0.
- R2: Status bit 1 is the receive enable. A `csr_wr` loads it from `csr_wdata[1]`. While it is 0 the line is ignored and no character is loaded. Clearing it during a frame abandons that frame.
- R3: A falling edge on the line is accepted as a start bit only if the line is still low 8 ticks later (mid-bit). A low pulse shorter than half a bit loads nothing.
- R4: A frame is: start bit 0, then `DATA_BITS` data bits least significant first, then the parity bit if `par_en`, then the wake-up bit if `wake_en`, then one stop bit. Each bit is sampled every 16 ticks. The data appears on `rx_data` with a one-cycle `rx_done` pulse.
- R5: Status bit 0 (character available) is set when a character is loaded and cleared by a `buf_rd` pulse. A write of 1 to bit 0 has no effect.
- R6: With `par_en` set, parity is even when `par_odd` is 0 and odd when it is 1. A mismatch sets status bit 2 as the character loads. The bit stays set until a `csr_wr` with `csr_wdata[2]`=1.
- R7: If a character loads while bit 0 is still set and no `buf_rd` occurs in that cycle, status bit 3 (overrun) is set together with that new character. It stays set until a `csr_wr` with `csr_wdata[3]`=1.
- R8: With `wake_en` set, `wake_match` is 1 for a character whose wake-up bit equals `wake_ref`, and 0 otherwise. With `wake_en` clear it is 0.
- R9: A stop bit sampled as 0 sets `frame_err` for that character, and the character is still loaded.
- R10: Status bits 7 to 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| wake_en | input | 1 | A wake-up bit follows parity |
| wake_ref | input | 1 | Expected wake-up bit value |
| csr_wr | input | 1 | Write strobe for the status/control byte |
| csr_wdata | input | 8 | Write data: bit1 enable, bit2 and bit3 write-1-to-clear |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| status | output | 8 | {0000, overrun, parity error, enable, available} |
| rx_data | output | DATA_BITS | Receive buffer |
| rx_done | output | 1 | One-cycle pulse when a character is loaded |
| frame_err | output | 1 | Stop bit was 0 for the buffered character |
| wake_match | output | 1 | Wake-up bit matched for the buffered character |

## Verification
Overrun is the hardest case to reach from the ports. It needs a second complete frame to land while the first is still unread. After that, the sticky flag must survive a later read and a clean third character, and be cleared only by its own write-1. The stimulus reaches this by sending frames back to back with no `buf_rd`. It then reads, sends a clean frame, and checks the overrun bit at each load before clearing it. A companion scenario drops the enable halfway through a frame and re-enables it only after the line has gone idle. This proves that the abandoned frame never loads.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int CSR_W     = 8;
    localparam int BIT_AVAIL = 0;
    localparam int BIT_EN    = 1;
    localparam int BIT_PERR  = 2;
    localparam int BIT_OVR   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_WAKE,
        ST_STOP
    } urx_state_e;

    typedef struct packed {
        logic par_err;
        logic frame_err;
        logic wake_match;
    } urx_flags_t;

    // 1 when the received parity bit disagrees with the programmed sense
    function automatic logic parity_fault(input logic data_xor,
                                          input logic par_bit,
                                          input logic odd);
        return data_xor ^ par_bit ^ odd;
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 rx_en,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 wake_en,
    input  logic                 wake_ref,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output urx_flags_t           flags
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] MID     = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_BITS - 1);

    urx_state_e           state;
    urx_state_e           after_data;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 pbad;
    logic                 wmatch;
    logic                 centre;

    always_comb begin
        after_data = par_en ? ST_PAR : (wake_en ? ST_WAKE : ST_STOP);
        centre     = (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            pbad   <= 1'b0;
            wmatch <= 1'b0;
            done   <= 1'b0;
            data   <= '0;
            flags  <= '0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!line) state <= ST_START;
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt    <= '0;
                            idx    <= '0;
                            pbad   <= 1'b0;
                            wmatch <= 1'b0;
                            state  <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            shreg <= (shreg >> 1) | (DATA_BITS'(line) << (DATA_BITS - 1));
                            if (idx == TOP_IDX) state <= after_data;
                            else                idx   <= idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            pbad  <= parity_fault(^shreg, line, par_odd);
                            state <= wake_en ? ST_WAKE : ST_STOP;
                        end
                    end
                    ST_WAKE: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            wmatch <= (line == wake_ref);
                            state  <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (centre) begin
                            done             <= 1'b1;
                            data             <= shreg;
                            flags.par_err    <= par_en & pbad;
                            flags.frame_err  <= ~line;
                            flags.wake_match <= wake_en & wmatch;
                            state            <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/urx_regs.sv
module urx_regs
    import urx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld,
    input  logic [DATA_BITS-1:0] ld_data,
    input  urx_flags_t           ld_flags,
    input  logic                 buf_rd,
    input  logic                 csr_wr,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     status,
    output logic                 rx_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_done,
    output logic                 frame_err,
    output logic                 wake_match
);
    logic avail, perr, ovr;
    logic unused_wbits;

    assign unused_wbits = ^{csr_wdata[CSR_W-1:BIT_OVR+1], csr_wdata[BIT_AVAIL]};

    always_ff @(posedge clk) begin
        if (rst) begin
            avail      <= 1'b0;
            rx_en      <= 1'b0;
            perr       <= 1'b0;
            ovr        <= 1'b0;
            rx_data    <= '0;
            rx_done    <= 1'b0;
            frame_err  <= 1'b0;
            wake_match <= 1'b0;
        end else begin
            rx_done <= ld;
            if (csr_wr) rx_en <= csr_wdata[BIT_EN];

            if (ld)          avail <= 1'b1;
            else if (buf_rd) avail <= 1'b0;

            if (ld && ld_flags.par_err)         perr <= 1'b1;
            else if (csr_wr && csr_wdata[BIT_PERR]) perr <= 1'b0;

            if (ld && avail && !buf_rd)         ovr <= 1'b1;
            else if (csr_wr && csr_wdata[BIT_OVR])  ovr <= 1'b0;

            if (ld) begin
                rx_data    <= ld_data;
                frame_err  <= ld_flags.frame_err;
                wake_match <= ld_flags.wake_match;
            end
        end
    end

    always_comb begin
        status            = '0;
        status[BIT_AVAIL] = avail;
        status[BIT_EN]    = rx_en;
        status[BIT_PERR]  = perr;
        status[BIT_OVR]   = ovr;
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import urx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 wake_en,
    input  logic                 wake_ref,
    input  logic                 csr_wr,
    input  logic [7:0]           csr_wdata,
    input  logic                 buf_rd,
    output logic [7:0]           status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_done,
    output logic                 frame_err,
    output logic                 wake_match
);
    logic                 line_s;
    logic                 en;
    logic                 ld;
    logic [DATA_BITS-1:0] ld_data;
    urx_flags_t           ld_flags;

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(line_s)
    );

    urx_frame #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .line    (line_s),
        .rx_en   (en),
        .par_en  (par_en),
        .par_odd (par_odd),
        .wake_en (wake_en),
        .wake_ref(wake_ref),
        .done    (ld),
        .data    (ld_data),
        .flags   (ld_flags)
    );

    urx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .ld_data   (ld_data),
        .ld_flags  (ld_flags),
        .buf_rd    (buf_rd),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .status    (status),
        .rx_en     (en),
        .rx_data   (rx_data),
        .rx_done   (rx_done),
        .frame_err (frame_err),
        .wake_match(wake_match)
    );
endmodule

// File: rtl/urx_checker.sv
module urx_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] flags,
    input logic       rx_done,
    input logic       buf_rd,
    input logic       clr_perr,
    input logic       clr_ovr
);
    // flags: [0] available, [1] enable, [2] parity error, [3] overrun

    assert_avail_from_load_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> rx_done);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        buf_rd |=> (!flags[0] || rx_done));

    assert_perr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !clr_perr) |=> flags[2]);

    assert_perr_with_char_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> rx_done);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flags[3] && !clr_ovr) |=> flags[3]);

    assert_ovr_needs_unread_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[3]) |-> (rx_done && $past(flags[0])));

    assert_no_load_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!flags[1] && $past(!flags[1])) |=> !rx_done);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);
endmodule

bind uart_rx_status urx_checker u_urx_chk (
    .clk     (clk),
    .rst     (rst),
    .flags   (status[3:0]),
    .rx_done (rx_done),
    .buf_rd  (buf_rd),
    .clr_perr(csr_wr & csr_wdata[2]),
    .clr_ovr (csr_wr & csr_wdata[3])
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;
    localparam int DB  = 8;
    localparam int BIT = 32;   // 16 ticks, one tick every other clock

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic os_tick = 1'b0, rxd = 1'b1;
    logic par_en = 0, par_odd = 0, wake_en = 0, wake_ref = 0;
    logic csr_wr = 0, buf_rd = 0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] status;
    logic [DB-1:0] rx_data;
    logic rx_done, frame_err, wake_match;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .wake_en(wake_en), .wake_ref(wake_ref),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .buf_rd(buf_rd),
        .status(status), .rx_data(rx_data), .rx_done(rx_done),
        .frame_err(frame_err), .wake_match(wake_match)
    );

    always @(posedge clk) os_tick <= rst ? 1'b0 : ~os_tick;

    typedef struct {
        logic [7:0] data;
        logic       perr;
        logic       ovr;
        logic       ferr;
        logic       wm;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   m_avail = 0, m_perr = 0, m_ovr = 0;
    bit   done_flag = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: pops one expected item per loaded character
    always @(negedge clk) begin
        exp_t e;
        if (!rst && rx_done) begin
            if (q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2/R3 unexpected load act=%0h exp=none", rx_data);
            end else begin
                e = q.pop_front();
                check("R4 data", rx_data, e.data);
                check("R5 available on load", status[0], 1);
                check("R6 parity flag", status[2], e.perr);
                check("R7 overrun flag", status[3], e.ovr);
                check("R9 framing", frame_err, e.ferr);
                check("R8 wake match", wake_match, e.wm);
            end
        end
    end

    task automatic bit_out(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic csr_write(input logic [7:0] d);
        csr_wr = 1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 0;
        if (d[2]) m_perr = 0;
        if (d[3]) m_ovr = 0;
    endtask

    task automatic read_buf();
        buf_rd = 1;
        @(negedge clk);
        buf_rd = 0;
        m_avail = 0;
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit wbit,
                             input bit stop_low, input bit expect_it);
        exp_t e;
        logic p;
        p = (^d) ^ par_odd ^ bad_par;
        if (expect_it) begin
            e.data = d;
            e.perr = m_perr | (par_en & bad_par);
            e.ovr  = m_ovr | m_avail;
            e.ferr = stop_low;
            e.wm   = wake_en & (wbit == wake_ref);
            q.push_back(e);
            m_perr = e.perr; m_ovr = e.ovr; m_avail = 1;
        end
        bit_out(0, BIT);
        for (int i = 0; i < 8; i++) bit_out(d[i], BIT);
        if (par_en)  bit_out(p, BIT);
        if (wake_en) bit_out(wbit, BIT);
        if (stop_low) begin
            bit_out(0, 20);
            bit_out(1, 3 * BIT - 20);
        end else begin
            bit_out(1, 3 * BIT);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 status after reset", status, 8'h00);
        check("R1 rx_done after reset", rx_done, 0);
        check("R1 rx_data after reset", rx_data, 0);
        check("R1 frame/wake after reset", {frame_err, wake_match}, 0);

        csr_write(8'hF3);
        check("R2 enable written", status[1], 1);
        check("R5 write to available ignored", status[0], 0);
        check("R10 upper bits zero", status[7:4], 0);

        send_char(8'hA5, 0, 0, 0, 1);
        check("R5 available held", status[0], 1);
        read_buf();
        check("R5 read clears available", status[0], 0);

        par_en = 1; par_odd = 0;
        send_char(8'h3C, 0, 0, 0, 1); read_buf();
        par_odd = 1;
        send_char(8'h3C, 0, 0, 0, 1); read_buf();
        send_char(8'h0F, 1, 0, 0, 1); read_buf();
        check("R6 parity error latched", status[2], 1);
        send_char(8'hF0, 0, 0, 0, 1); read_buf();
        check("R6 parity error survives clean char", status[2], 1);
        csr_write(8'h06);
        check("R6 write-1 clears parity error", status, 8'h02);
        par_en = 0;

        send_char(8'h11, 0, 0, 0, 1);
        send_char(8'h22, 0, 0, 0, 1);
        check("R7 overrun set", status[3], 1);
        read_buf();
        send_char(8'h33, 0, 0, 0, 1); read_buf();
        check("R7 overrun still set", status[3], 1);
        csr_write(8'h0A);
        check("R7 write-1 clears overrun", status, 8'h02);

        par_en = 1; par_odd = 0; wake_en = 1; wake_ref = 1;
        send_char(8'h55, 0, 1, 0, 1); read_buf();
        send_char(8'h55, 0, 0, 0, 1); read_buf();
        wake_ref = 0;
        send_char(8'hAA, 0, 0, 0, 1); read_buf();
        wake_en = 0; par_en = 0;

        send_char(8'h7E, 0, 0, 1, 1);
        check("R9 char kept on framing error", status[0], 1);
        read_buf();
        send_char(8'h81, 0, 0, 0, 1); read_buf();

        bit_out(0, 10);
        bit_out(1, 12 * BIT);
        check("R3 glitch loads nothing", status[0], 0);
        send_char(8'h5A, 0, 0, 0, 1); read_buf();

        csr_write(8'h00);
        send_char(8'hC3, 0, 0, 0, 0);
        check("R2 disabled receiver idle", status, 8'h00);
        csr_write(8'h02);
        fork
            send_char(8'hC3, 0, 0, 0, 0);
            begin
                repeat (3 * BIT) @(negedge clk);
                csr_write(8'h00);
            end
        join
        csr_write(8'h02);
        repeat (4 * BIT) @(negedge clk);
        check("R2 aborted frame not loaded", status[0], 0);
        send_char(8'h3C, 0, 0, 0, 1); read_buf();

        check("R4 all expected characters seen", q.size(), 0);
        finish_run();
    end
endmodule